// File: doc/BRIEF.md
# Synthesizer Test-Mode and Port Control

This block sits beside a PLL frequency synthesizer and interprets a three-bit test code. One code value sets three things at once. It can force the charge-pump command to sink, source or off. It can replace the lock flag reported to software with a fixed value. It can route an internal divider clock onto a general-purpose open-drain port. When no clock test code is active, a single port bit switches the port sink on or off.

A toggle flop halves the rate of the programmable-divider output pulse so that this output can be observed on the port. The forced pump states and the lock-flag override only work while both the divider and reference pulse trains are running. A watch counter on each train decides whether it counts as present. While either train is missing, the pump stays in normal mode and the real lock flag is reported.

Top module: `synth_testmode_ctrl`

## Requirements
- R1: During and after reset, the registered test code is 000, the port enable is 0 (high impedance), the halved divider clock is 0 and the pump command is normal.
- R2: When the low two bits of the registered code are 00, the pump command is normal (encoding 2'b00) and `fl_o` equals `lock_raw_i`.
- R3: When both pulse trains are present, low code bits 01 give pump sink (2'b01) with `fl_o`=0, 10 give source (2'b10) with `fl_o`=0, and 11 give off (2'b11) with `fl_o`=1.
- R4: A train is present only if it pulsed on at least one of the last ACT_WIN clock edges. If either train is absent, the pump command is normal and `fl_o` equals `lock_raw_i`, whatever the code.
- R5: For codes 000..011, `port_oe_o` equals the registered port bit: 1 turns the open-drain sink on, 0 leaves the port off.
- R6: The halved divider clock inverts on the edge that follows each `fdiv_pulse_i` high sample. For code 100 it drives `port_oe_o`.
- R7: For codes 101, 110 and 111, `port_oe_o` equals `fref_pulse_i` delayed by one clock.
- R8: The test code and port bit are registered, so a change takes effect at the next clock edge.
- R9: `port_val_o` is always 0. The port only ever sinks, and the enable gates it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmode_i | input | 3 | Test code |
| port_bit_i | input | 1 | Port on/off bit |
| lock_raw_i | input | 1 | Lock detector flag |
| fdiv_pulse_i | input | 1 | Programmable-divider output pulse |
| fref_pulse_i | input | 1 | Reference-divider output pulse |
| cp_mode_o | output | 2 | Pump command: 00 normal, 01 sink, 10 source, 11 off |
| fl_o | output | 1 | Reported lock flag |
| port_val_o | output | 1 | Port drive value (sink) |
| port_oe_o | output | 1 | Port drive enable |

## Verification
The checker tests on every cycle the following:
- the one-edge registration of the code;
- the pump command and lock override while both trains are present;
- pass-through of the raw flag for code x00;
- inversion of the halved clock after each divider pulse;
- routing of the port enable for each code group;
- the idle port during reset.

The fallback to normal behaviour when a train stops is shown only by bench scenarios. These scenarios starve the pulse inputs for longer than the watch window and change codes while the pulses are absent. The bench also covers a reset applied in the middle of the run.

// File: rtl/synth_tm_pkg.sv
package synth_tm_pkg;
  typedef enum logic [1:0] {
    CP_NORMAL = 2'b00,
    CP_SINK   = 2'b01,
    CP_SOURCE = 2'b10,
    CP_OFF    = 2'b11
  } cp_mode_e;

  localparam int unsigned CODE_W = 3;
endpackage

// File: rtl/stm_code_reg.sv
module stm_code_reg
  import synth_tm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code_i,
  input  logic              pbit_i,
  output logic [CODE_W-1:0] code_q,
  output logic              pbit_q
);
  logic [CODE_W-1:0] code_d;
  logic              pbit_d;
  logic              load_en;

  assign load_en = 1'b1;

  always_comb begin
    code_d = code_q;
    pbit_d = pbit_q;
    if (load_en) begin
      code_d = code_i;
      pbit_d = pbit_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      pbit_q <= 1'b0;
    end else begin
      code_q <= code_d;
      pbit_q <= pbit_d;
    end
  end
endmodule

// File: rtl/stm_clk_watch.sv
module stm_clk_watch #(
  parameter int unsigned ACT_WIN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_i,
  output logic alive_o
);
  localparam int unsigned CNT_W = $clog2(ACT_WIN + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(ACT_WIN);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = pulse_i || (cnt_q < CNT_MAX);

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en) begin
      if (pulse_i) cnt_d = '0;
      else         cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= CNT_MAX;
    else        cnt_q <= cnt_d;
  end

  assign alive_o = (cnt_q < CNT_MAX);
endmodule

// File: rtl/stm_port_path.sv
module stm_port_path
  import synth_tm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code_q,
  input  logic              pbit_q,
  input  logic              fdiv_pulse_i,
  input  logic              fref_pulse_i,
  output logic              half_q,
  output logic              port_oe_o
);
  logic half_d;
  logic fref_q, fref_d;

  always_comb begin
    half_d = half_q;
    if (fdiv_pulse_i) half_d = ~half_q;
    fref_d = fref_pulse_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= 1'b0;
      fref_q <= 1'b0;
    end else begin
      half_q <= half_d;
      fref_q <= fref_d;
    end
  end

  always_comb begin
    if (!code_q[2])                port_oe_o = pbit_q;
    else if (code_q[1:0] == 2'b00) port_oe_o = half_q;
    else                           port_oe_o = fref_q;
  end
endmodule

// File: rtl/stm_decode.sv
module stm_decode
  import synth_tm_pkg::*;
(
  input  logic [CODE_W-1:0] code_q,
  input  logic              clk_ok_i,
  input  logic              lock_raw_i,
  output logic [1:0]        cp_mode_o,
  output logic              fl_o
);
  logic     forced;
  cp_mode_e mode;

  assign forced = (code_q[1:0] != 2'b00) && clk_ok_i;

  always_comb begin
    mode = CP_NORMAL;
    fl_o = lock_raw_i;
    if (forced) begin
      mode = cp_mode_e'(code_q[1:0]);
      fl_o = (code_q[1:0] == 2'b11);
    end
  end

  assign cp_mode_o = mode;
endmodule

// File: rtl/synth_testmode_ctrl.sv
module synth_testmode_ctrl
  import synth_tm_pkg::*;
#(
  parameter int unsigned ACT_WIN = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] tmode_i,
  input  logic       port_bit_i,
  input  logic       lock_raw_i,
  input  logic       fdiv_pulse_i,
  input  logic       fref_pulse_i,
  output logic [1:0] cp_mode_o,
  output logic       fl_o,
  output logic       port_val_o,
  output logic       port_oe_o
);
  localparam int unsigned N_SRC = 2;

  logic [CODE_W-1:0] code_q;
  logic              pbit_q;
  logic              half_q;
  logic [N_SRC-1:0]  src_pulse;
  logic [N_SRC-1:0]  src_alive;
  logic              clk_ok;

  assign src_pulse = {fref_pulse_i, fdiv_pulse_i};

  stm_code_reg u_code (
    .clk(clk), .rst_n(rst_n), .code_i(tmode_i), .pbit_i(port_bit_i),
    .code_q(code_q), .pbit_q(pbit_q)
  );

  for (genvar g = 0; g < N_SRC; g++) begin : g_watch
    stm_clk_watch #(.ACT_WIN(ACT_WIN)) u_watch (
      .clk(clk), .rst_n(rst_n), .pulse_i(src_pulse[g]), .alive_o(src_alive[g])
    );
  end

  assign clk_ok = &src_alive;

  stm_decode u_dec (
    .code_q(code_q), .clk_ok_i(clk_ok), .lock_raw_i(lock_raw_i),
    .cp_mode_o(cp_mode_o), .fl_o(fl_o)
  );

  stm_port_path u_port (
    .clk(clk), .rst_n(rst_n), .code_q(code_q), .pbit_q(pbit_q),
    .fdiv_pulse_i(fdiv_pulse_i), .fref_pulse_i(fref_pulse_i),
    .half_q(half_q), .port_oe_o(port_oe_o)
  );

  assign port_val_o = 1'b0;
endmodule

// File: rtl/synth_testmode_ctrl_chk.sv
module synth_testmode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] tmode_i,
  input logic       port_bit_i,
  input logic       lock_raw_i,
  input logic       fdiv_pulse_i,
  input logic       fref_pulse_i,
  input logic [1:0] cp_mode_o,
  input logic       fl_o,
  input logic       port_oe_o,
  input logic [2:0] code_q,
  input logic       clk_ok,
  input logic       half_q
);
  always @(posedge clk) begin
    if (!rst_n) begin
      p_idle_port_r1: assert (port_oe_o == 1'b0 && half_q == 1'b0 && code_q == 3'b000);
    end
  end

  p_normal_fl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q[1:0] == 2'b00) |-> (cp_mode_o == 2'b00 && fl_o == lock_raw_i));

  p_forced_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_ok && code_q[1:0] != 2'b00) |-> (cp_mode_o == code_q[1:0] && fl_o == (code_q[1:0] == 2'b11)));

  p_p0_route_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmode_i[2]) |=> (port_oe_o == $past(port_bit_i)));

  p_half_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fdiv_pulse_i |=> (half_q != $past(half_q)));

  p_half_route_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q == 3'b100) |-> (port_oe_o == half_q));

  p_fref_route_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tmode_i[2] && tmode_i[1:0] != 2'b00) |=> (port_oe_o == $past(fref_pulse_i)));

  p_code_reg_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (code_q == $past(tmode_i)));
endmodule

bind synth_testmode_ctrl synth_testmode_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tmode_i(tmode_i), .port_bit_i(port_bit_i),
  .lock_raw_i(lock_raw_i), .fdiv_pulse_i(fdiv_pulse_i), .fref_pulse_i(fref_pulse_i),
  .cp_mode_o(cp_mode_o), .fl_o(fl_o), .port_oe_o(port_oe_o),
  .code_q(code_q), .clk_ok(clk_ok), .half_q(half_q)
);

// File: tb/synth_testmode_ctrl_tb_top.sv
`timescale 1ns/1ps
module synth_testmode_ctrl_tb_top;
  localparam int unsigned WIN = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] tmode;
  logic       pbit, lock_raw, fdiv, fref;
  logic [1:0] cp_mode;
  logic       fl, pval, poe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model state
  logic [2:0] m_code;
  logic       m_p0, m_half, m_fref;
  int         m_ca, m_cb;

  always #10 clk = ~clk;

  synth_testmode_ctrl #(.ACT_WIN(WIN)) dut_i (
    .clk(clk), .rst_n(rst_n), .tmode_i(tmode), .port_bit_i(pbit),
    .lock_raw_i(lock_raw), .fdiv_pulse_i(fdiv), .fref_pulse_i(fref),
    .cp_mode_o(cp_mode), .fl_o(fl), .port_val_o(pval), .port_oe_o(poe)
  );

  function automatic logic [1:0] exp_cp(input logic [2:0] c, input bit ok);
    return (ok && c[1:0] != 2'b00) ? c[1:0] : 2'b00;
  endfunction

  function automatic logic exp_fl(input logic [2:0] c, input bit ok, input logic raw);
    return (ok && c[1:0] != 2'b00) ? (c[1:0] == 2'b11) : raw;
  endfunction

  function automatic logic exp_oe(input logic [2:0] c, input logic p, input logic h, input logic f);
    if (!c[2]) return p;
    if (c[1:0] == 2'b00) return h;
    return f;
  endfunction

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b (code %03b)", req, act, exp, m_code);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_code = 3'b000; m_p0 = 1'b0; m_half = 1'b0; m_fref = 1'b0;
      m_ca = WIN; m_cb = WIN;
    end else begin
      if (fdiv) m_half = ~m_half;
      m_fref = fref;
      if (fdiv) m_ca = 0; else if (m_ca < WIN) m_ca++;
      if (fref) m_cb = 0; else if (m_cb < WIN) m_cb++;
      m_code = tmode; m_p0 = pbit;
    end
  end

  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      automatic bit ok = (m_ca < WIN) && (m_cb < WIN);
      string r;
      if (m_code[1:0] == 2'b00) r = "R2"; else if (ok) r = "R3"; else r = "R4";
      check(r, cp_mode, exp_cp(m_code, ok));
      check(r, {1'b0, fl}, {1'b0, exp_fl(m_code, ok, lock_raw)});
      if (!m_code[2]) r = "R5/R8"; else if (m_code[1:0] == 2'b00) r = "R6"; else r = "R7";
      check(r, {1'b0, poe}, {1'b0, exp_oe(m_code, m_p0, m_half, m_fref)});
      check("R9", {1'b0, pval}, 2'b00);
    end
  end

  task automatic drive(input int pulse_pct);
    @(negedge clk);
    tmode    = 3'($urandom_range(7, 0));
    pbit     = 1'($urandom_range(1, 0));
    lock_raw = 1'($urandom_range(1, 0));
    fdiv     = ($urandom_range(99, 0) < pulse_pct);
    fref     = ($urandom_range(99, 0) < pulse_pct);
  endtask

  task automatic reset_check();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R1: idle state while held in reset
    check("R1", cp_mode, 2'b00);
    check("R1", {1'b0, poe}, 2'b00);
    check("R1", {1'b0, fl}, {1'b0, lock_raw});
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd1207));
    rst_n = 1'b0; tmode = 3'b011; pbit = 1'b1; lock_raw = 1'b0; fdiv = 1'b0; fref = 1'b0;
    reset_check();
    // directed: forced code with no clocks yet -> R4 fallback
    @(negedge clk); tmode = 3'b011; lock_raw = 1'b0;
    repeat (4) @(negedge clk);
    // directed: start both trains, then code 011 gives off/FL=1 (R3)
    fdiv = 1'b1; fref = 1'b1;
    @(negedge clk); fdiv = 1'b0; fref = 1'b0;
    repeat (3) @(negedge clk);
    // directed: code 100 with steady divider pulses (R6)
    tmode = 3'b100;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); fdiv = 1'b1; fref = (i % 3 == 0);
    end
    for (int i = 0; i < 3000; i++) drive(35);
    for (int i = 0; i < 400; i++) drive(2);
    reset_check();
    for (int i = 0; i < 1500; i++) drive(20);
    // starve only the reference train
    for (int i = 0; i < 60; i++) begin
      drive(0); fdiv = 1'b1;
    end
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule